// File: doc/BRIEF.md
# Dual-Bus Stacked-Memory Channel Scheduler

This block issues commands for one channel of a stacked DRAM that has two separate command buses: one carries row operations (activate, precharge) and the other carries column operations (read, write). In any cycle the scheduler can put one row operation and one column operation on the wires, provided they address different banks. Requests enter through a ready/valid port. Each request carries a bank, a row, a column, a write flag and a tag. Requests wait in a small window, oldest first. The scheduler tracks which row is open in every bank and enforces activate-to-column, precharge-to-activate and column-to-column spacing. It also keeps each data bus busy for a full burst after a column command.

The channel mode is taken from `pseudo_en` while reset is asserted and stays fixed until the next reset. In wide mode the channel is one 128-bit path with eight banks and bursts of two beats on a single data bus. In split mode the channel becomes two 64-bit halves. Each half has eight banks of its own, so sixteen banks are managed, and each half has its own data bus with bursts of four beats. Pages are half as long in split mode, so the top column bit is dropped. A read returns its tag on `rd_valid`/`rd_tag` a fixed number of cycles after its column command.

Top module: `hbm_dual_cmd_sched`

## Requirements
- R1: After reset no row or column command is driven, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request to a closed bank produces an activate (`row_cmd_act`=1) with the request's row, and then its column command exactly T_RCD cycles later when nothing else blocks it.
- R3: A request whose row is already open in its bank produces a column command only and no row command.
- R4: A request to a bank with a different open row produces a precharge (`row_cmd_act`=0), then an activate exactly T_RP cycles later, then its column command T_RCD cycles after that.
- R5: A row command and a column command may go out in the same cycle when their banks differ. They never share a bank in one cycle. If both would target the same bank, the column command goes first and the row command is held back.
- R6: Two column commands to the same bank are at least T_CCD cycles apart.
- R7: In wide mode all column commands share one data bus and are at least BL_LEG cycles apart. In split mode column commands to the same half are at least BL_PC cycles apart, while commands to different halves may go out in consecutive cycles.
- R8: The command bank field is {half, bank}. In wide mode the half bit is always 0 and `req_pc` is ignored. In split mode it equals `req_pc`.
- R9: In split mode the top bit of `col_cmd_col` is driven 0. In wide mode the column is passed through unchanged.
- R10: Among requests whose column command is ready, the oldest one is issued first. A younger ready request may pass an older one that is still waiting for its row.
- R11: A read (`req_we`=0) returns its tag on `rd_tag` with `rd_valid` exactly RD_LAT cycles after its column command, in column order. Writes (`req_we`=1) return nothing.
- R12: `req_ready` is 0 while the window holds WIN requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pseudo_en | input | 1 | Mode, sampled during reset: 1 = split, 0 = wide |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Window has space |
| req_pc | input | 1 | Half select (split mode only) |
| req_bank | input | BA_W | Bank within a half |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request tag |
| row_cmd_valid | output | 1 | Row command issued this cycle |
| row_cmd_act | output | 1 | 1 = activate, 0 = precharge |
| row_cmd_bank | output | BA_W+1 | Row command bank {half, bank} |
| row_cmd_row | output | ROW_W | Row being activated |
| col_cmd_valid | output | 1 | Column command issued this cycle |
| col_cmd_we | output | 1 | 1 = write, 0 = read |
| col_cmd_bank | output | BA_W+1 | Column command bank {half, bank} |
| col_cmd_col | output | COL_W | Column address |
| rd_valid | output | 1 | Read tag return |
| rd_tag | output | TAG_W | Returned tag |

## Verification
The hardest case to produce from the ports is a row candidate and a column candidate that both point at the same bank in the same cycle. The stimulus sends two back-to-back requests to one bank with different rows. The second request then wants a precharge in exactly the cycle the first one's column becomes legal, and the bench checks that the precharge lands T_CCD cycles after that column. A true same-cycle dual issue is set up the same way. A miss is sent, one cycle is skipped, and a hit to another bank follows, so the activate and the column meet in one cycle. The bench then sweeps all banks through miss, hit and conflict in wide mode and repeats bus-spacing and ordering patterns in split mode.

// File: rtl/hbm_sched_pkg.sv
package hbm_sched_pkg;

   typedef enum logic {
      ROW_PRE = 1'b0,
      ROW_ACT = 1'b1
   } row_op_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/hbm_bank_ctl.sv
module hbm_bank_ctl #(
   parameter int ROW_W = 14,
   parameter int T_RCD = 3,
   parameter int T_RP  = 2,
   parameter int T_CCD = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             pre_i,
   input  logic             col_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             act_ok_o,
   output logic             quiet_o
);
   import hbm_sched_pkg::*;

   localparam int TMAX = max3(T_RCD, T_RP, T_CCD);
   localparam int CW   = $clog2(TMAX + 1);

   logic             open_q;
   logic [ROW_W-1:0] row_q;
   logic [CW-1:0]    rcd_q, rp_q, ccd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         row_q  <= '0;
         rcd_q  <= '0;
         rp_q   <= '0;
         ccd_q  <= '0;
      end else begin
         if (act_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
         end else if (pre_i) begin
            open_q <= 1'b0;
         end
         rcd_q <= act_i ? CW'(T_RCD - 1) : ((rcd_q != '0) ? rcd_q - 1'b1 : rcd_q);
         rp_q  <= pre_i ? CW'(T_RP - 1)  : ((rp_q  != '0) ? rp_q  - 1'b1 : rp_q);
         ccd_q <= col_i ? CW'(T_CCD - 1) : ((ccd_q != '0) ? ccd_q - 1'b1 : ccd_q);
      end
   end

   assign open_o   = open_q;
   assign row_o    = row_q;
   assign act_ok_o = !open_q && (rp_q == '0);
   assign quiet_o  = (rcd_q == '0) && (ccd_q == '0);

   // R2: a column goes only to an open bank whose activate delay has expired
   p_col_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
      col_i |-> (open_q && rcd_q == '0));
   // R4: an activate goes only to a closed bank whose precharge delay has expired
   p_act_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> (!open_q && rp_q == '0));
   // R4: a precharge goes only to an open, quiet bank
   p_pre_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_i |-> (open_q && rcd_q == '0 && ccd_q == '0));
   // R6: column-to-column spacing within one bank
   p_ccd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      col_i |=> (ccd_q == CW'(T_CCD - 1)));
   // R5: row and column never hit this bank together
   p_no_dual_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      col_i |-> !(act_i || pre_i));

endmodule

// File: rtl/hbm_bus_track.sv
module hbm_bus_track #(
   parameter int BL_A = 2,
   parameter int BL_B = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_b_i,
   input  logic col_i,
   output logic free_o
);
   localparam int BMAX = (BL_A > BL_B) ? BL_A : BL_B;
   localparam int CW   = $clog2(BMAX + 1);

   logic [CW-1:0] busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_q <= '0;
      else if (col_i) busy_q <= sel_b_i ? CW'(BL_B - 1) : CW'(BL_A - 1);
      else if (busy_q != '0) busy_q <= busy_q - 1'b1;
   end

   assign free_o = (busy_q == '0);

   // R7: a new burst only starts on an idle data bus
   p_bus_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      col_i |-> (busy_q == '0));

endmodule

// File: rtl/hbm_rd_pipe.sv
module hbm_rd_pipe #(
   parameter int TAG_W = 4,
   parameter int LAT   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vld_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             vld_o,
   output logic [TAG_W-1:0] tag_o
);
   logic [LAT-1:0]   v_q;
   logic [TAG_W-1:0] t_q [LAT];

   for (genvar k = 0; k < LAT; k++) begin : g_stage
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q[0] <= 1'b0;
               t_q[0] <= '0;
            end else begin
               v_q[0] <= vld_i;
               t_q[0] <= tag_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q[k] <= 1'b0;
               t_q[k] <= '0;
            end else begin
               v_q[k] <= v_q[k-1];
               t_q[k] <= t_q[k-1];
            end
         end
      end
   end

   assign vld_o = v_q[LAT-1];
   assign tag_o = t_q[LAT-1];

endmodule

// File: rtl/hbm_dual_cmd_sched.sv
module hbm_dual_cmd_sched
   import hbm_sched_pkg::*;
#(
   parameter int BANKS  = 8,
   parameter int ROW_W  = 14,
   parameter int COL_W  = 6,
   parameter int TAG_W  = 4,
   parameter int WIN    = 4,
   parameter int T_RCD  = 3,
   parameter int T_RP   = 2,
   parameter int T_CCD  = 2,
   parameter int RD_LAT = 4,
   parameter int BL_LEG = 2,
   parameter int BL_PC  = 4,
   localparam int BA_W  = $clog2(BANKS),
   localparam int GB_W  = BA_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pseudo_en,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_pc,
   input  logic [BA_W-1:0]  req_bank,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic             req_we,
   input  logic [TAG_W-1:0] req_tag,
   output logic             row_cmd_valid,
   output logic             row_cmd_act,
   output logic [GB_W-1:0]  row_cmd_bank,
   output logic [ROW_W-1:0] row_cmd_row,
   output logic             col_cmd_valid,
   output logic             col_cmd_we,
   output logic [GB_W-1:0]  col_cmd_bank,
   output logic [COL_W-1:0] col_cmd_col,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag
);
   localparam int NB = 2 * BANKS;
   localparam int SW = (WIN > 1) ? $clog2(WIN) : 1;

   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $fatal(1, "BANKS must be a power of two of at least 2");
   end
   if (T_RCD < 1 || T_RP < 1 || T_CCD < 1 || RD_LAT < 1) begin : g_bad_timing
      $fatal(1, "timing parameters must be at least 1");
   end
   if (BL_LEG < 1 || BL_PC < 1 || WIN < 2 || COL_W < 2) begin : g_bad_shape
      $fatal(1, "burst, window or column parameters out of range");
   end

   // mode captured during reset
   logic mode_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= pseudo_en;
   end

   // request window, slot 0 is oldest
   logic [WIN-1:0]   s_v, n_v, s_we, n_we;
   logic [GB_W-1:0]  s_bk [WIN];
   logic [GB_W-1:0]  n_bk [WIN];
   logic [ROW_W-1:0] s_row[WIN];
   logic [ROW_W-1:0] n_row[WIN];
   logic [COL_W-1:0] s_col[WIN];
   logic [COL_W-1:0] n_col[WIN];
   logic [TAG_W-1:0] s_tag[WIN];
   logic [TAG_W-1:0] n_tag[WIN];

   // bank and bus state
   logic [NB-1:0]    bk_open, bk_act_ok, bk_quiet;
   logic [ROW_W-1:0] bk_row [NB];
   logic [1:0]       bus_free;

   // candidates
   logic [WIN-1:0]   hit, col_rdy, row_rdy;
   logic             col_go, row_found, row_go;
   logic [SW-1:0]    col_sel, row_sel;
   logic [GB_W-1:0]  col_bk, row_bk;
   logic             col_bus;
   row_op_e          row_op;

   always_comb begin
      for (int i = 0; i < WIN; i++) begin
         logic [GB_W-1:0] b;
         logic            bus;
         b          = s_bk[i];
         bus        = mode_q & b[GB_W-1];
         hit[i]     = s_v[i] && bk_open[b] && (bk_row[b] == s_row[i]);
         col_rdy[i] = hit[i] && bk_quiet[b] && bus_free[bus];
         row_rdy[i] = s_v[i] && !hit[i] && (bk_open[b] ? bk_quiet[b] : bk_act_ok[b]);
      end
   end

   always_comb begin
      col_go    = 1'b0;
      col_sel   = '0;
      row_found = 1'b0;
      row_sel   = '0;
      for (int i = WIN - 1; i >= 0; i--) begin
         if (col_rdy[i]) begin
            col_go  = 1'b1;
            col_sel = SW'(i);
         end
         if (row_rdy[i]) begin
            row_found = 1'b1;
            row_sel   = SW'(i);
         end
      end
   end

   assign col_bk  = s_bk[col_sel];
   assign row_bk  = s_bk[row_sel];
   assign col_bus = mode_q & col_bk[GB_W-1];
   assign row_op  = bk_open[row_bk] ? ROW_PRE : ROW_ACT;
   // column wins a same-bank collision
   assign row_go  = row_found && !(col_go && (row_bk == col_bk));

   assign req_ready = !s_v[WIN-1];

   // compaction on removal, insertion behind the last valid slot
   always_comb begin
      int wpos;
      logic ins;
      ins  = req_valid && req_ready;
      wpos = $countones(s_v) - (col_go ? 1 : 0);
      for (int i = 0; i < WIN; i++) begin
         int src;
         src = (col_go && i >= int'(col_sel)) ? i + 1 : i;
         if (src < WIN) begin
            n_v[i]   = s_v[src];
            n_we[i]  = s_we[src];
            n_bk[i]  = s_bk[src];
            n_row[i] = s_row[src];
            n_col[i] = s_col[src];
            n_tag[i] = s_tag[src];
         end else begin
            n_v[i]   = 1'b0;
            n_we[i]  = s_we[i];
            n_bk[i]  = s_bk[i];
            n_row[i] = s_row[i];
            n_col[i] = s_col[i];
            n_tag[i] = s_tag[i];
         end
         if (ins && i == wpos) begin
            n_v[i]   = 1'b1;
            n_we[i]  = req_we;
            n_bk[i]  = {mode_q & req_pc, req_bank};
            n_row[i] = req_row;
            n_col[i] = mode_q ? {1'b0, req_col[COL_W-2:0]} : req_col;
            n_tag[i] = req_tag;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_v  <= '0;
         s_we <= '0;
         for (int i = 0; i < WIN; i++) begin
            s_bk[i]  <= '0;
            s_row[i] <= '0;
            s_col[i] <= '0;
            s_tag[i] <= '0;
         end
      end else begin
         s_v   <= n_v;
         s_we  <= n_we;
         s_bk  <= n_bk;
         s_row <= n_row;
         s_col <= n_col;
         s_tag <= n_tag;
      end
   end

   for (genvar g = 0; g < NB; g++) begin : g_bank
      hbm_bank_ctl #(
         .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_CCD(T_CCD)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .act_i    (row_go && row_op == ROW_ACT && row_bk == GB_W'(g)),
         .pre_i    (row_go && row_op == ROW_PRE && row_bk == GB_W'(g)),
         .col_i    (col_go && col_bk == GB_W'(g)),
         .row_i    (s_row[row_sel]),
         .open_o   (bk_open[g]),
         .row_o    (bk_row[g]),
         .act_ok_o (bk_act_ok[g]),
         .quiet_o  (bk_quiet[g])
      );
   end

   for (genvar g = 0; g < 2; g++) begin : g_bus
      hbm_bus_track #(.BL_A(BL_LEG), .BL_B(BL_PC)) u_bus (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_b_i (mode_q),
         .col_i   (col_go && col_bus == 1'(g)),
         .free_o  (bus_free[g])
      );
   end

   hbm_rd_pipe #(.TAG_W(TAG_W), .LAT(RD_LAT)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (col_go && !s_we[col_sel]),
      .tag_i (s_tag[col_sel]),
      .vld_o (rd_valid),
      .tag_o (rd_tag)
   );

   assign row_cmd_valid = row_go;
   assign row_cmd_act   = (row_op == ROW_ACT);
   assign row_cmd_bank  = row_bk;
   assign row_cmd_row   = s_row[row_sel];
   assign col_cmd_valid = col_go;
   assign col_cmd_we    = s_we[col_sel];
   assign col_cmd_bank  = col_bk;
   assign col_cmd_col   = s_col[col_sel];

   // R5: the two buses never address one bank in the same cycle
   p_split_banks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (row_cmd_valid && col_cmd_valid) |-> (row_cmd_bank != col_cmd_bank));
   // R8: wide mode never addresses the upper half
   p_wide_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && (row_cmd_valid || col_cmd_valid)) |->
         !(row_cmd_bank[GB_W-1] && row_cmd_valid) && !(col_cmd_bank[GB_W-1] && col_cmd_valid));
   // R9: split mode column top bit is zero
   p_half_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && col_cmd_valid) |-> !col_cmd_col[COL_W-1]);
   // R12: an accepted request occupies one more slot unless one leaves
   p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !col_cmd_valid) |=>
         ($countones(s_v) == $countones($past(s_v)) + 1));

endmodule

// File: tb/test_hbm_dual_cmd_sched.sv
module test_hbm_dual_cmd_sched;
   localparam int CLK_P  = 10;
   localparam int BANKS  = 8;
   localparam int BA_W   = 3;
   localparam int GB_W   = 4;
   localparam int ROW_W  = 14;
   localparam int COL_W  = 6;
   localparam int TAG_W  = 4;
   localparam int WIN    = 4;
   localparam int T_RCD  = 3;
   localparam int T_RP   = 2;
   localparam int T_CCD  = 3;
   localparam int RD_LAT = 4;
   localparam int BL_LEG = 2;
   localparam int BL_PC  = 4;
   localparam int LOGN   = 512;

   logic             clk, rst_n, pseudo_en;
   logic             req_valid, req_ready, req_pc, req_we;
   logic [BA_W-1:0]  req_bank;
   logic [ROW_W-1:0] req_row;
   logic [COL_W-1:0] req_col;
   logic [TAG_W-1:0] req_tag;
   logic             row_cmd_valid, row_cmd_act, col_cmd_valid, col_cmd_we, rd_valid;
   logic [GB_W-1:0]  row_cmd_bank, col_cmd_bank;
   logic [ROW_W-1:0] row_cmd_row;
   logic [COL_W-1:0] col_cmd_col;
   logic [TAG_W-1:0] rd_tag;

   hbm_dual_cmd_sched #(
      .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W), .WIN(WIN),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_CCD(T_CCD), .RD_LAT(RD_LAT),
      .BL_LEG(BL_LEG), .BL_PC(BL_PC)
   ) i_hbm_dual_cmd_sched (
      .clk(clk), .rst_n(rst_n), .pseudo_en(pseudo_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_pc(req_pc),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_we(req_we), .req_tag(req_tag),
      .row_cmd_valid(row_cmd_valid), .row_cmd_act(row_cmd_act),
      .row_cmd_bank(row_cmd_bank), .row_cmd_row(row_cmd_row),
      .col_cmd_valid(col_cmd_valid), .col_cmd_we(col_cmd_we),
      .col_cmd_bank(col_cmd_bank), .col_cmd_col(col_cmd_col),
      .rd_valid(rd_valid), .rd_tag(rd_tag)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;
   int cyc   = 0;

   // command logs
   int rc[LOGN]; int ra[LOGN]; int rb[LOGN]; int rr[LOGN]; int nr = 0;
   int cc[LOGN]; int cw[LOGN]; int cb[LOGN]; int ccol[LOGN]; int nc = 0;
   int dc[LOGN]; int dt[LOGN]; int nd = 0;

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (row_cmd_valid && nr < LOGN) begin
         rc[nr] = cyc; ra[nr] = int'(row_cmd_act); rb[nr] = int'(row_cmd_bank);
         rr[nr] = int'(row_cmd_row); nr++;
      end
      if (col_cmd_valid && nc < LOGN) begin
         cc[nc] = cyc; cw[nc] = int'(col_cmd_we); cb[nc] = int'(col_cmd_bank);
         ccol[nc] = int'(col_cmd_col); nc++;
      end
      if (rd_valid && nd < LOGN) begin
         dc[nd] = cyc; dt[nd] = int'(rd_tag); nd++;
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input bit pc, input int bk, input int row, input int col,
                       input bit we, input int tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_pc    = pc;
      req_bank  = BA_W'(bk);
      req_row   = ROW_W'(row);
      req_col   = COL_W'(col);
      req_we    = we;
      req_tag   = TAG_W'(tag);
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
   endtask

   task automatic do_reset(input bit m);
      req_valid = 1'b0;
      pseudo_en = m;
      rst_n     = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 row idle", int'(row_cmd_valid), 0);
      chk("R1 col idle", int'(col_cmd_valid), 0);
      chk("R1 rd idle", int'(rd_valid), 0);
      chk("R1 ready", int'(req_ready), 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int br, bc, bd;
      req_pc = 0; req_bank = '0; req_row = '0; req_col = '0; req_we = 0; req_tag = '0;
      do_reset(1'b0);

      // wide mode sweep: miss, hit (write), conflict on every bank
      for (int b = 0; b < BANKS; b++) begin
         br = nr; bc = nc; bd = nd;
         send(1'b1, b, 10 + b, b, 1'b0, b);
         idle(15);
         send(1'b0, b, 10 + b, b + 8, 1'b1, b + 8);
         idle(15);
         send(1'b1, b, 40 + b, b, 1'b0, (b + 3) % 16);
         idle(20);
         chk("R3 row cmd count", nr - br, 3);
         chk("R2 first is activate", ra[br], 1);
         chk("R8 wide bank ignores pc", rb[br], b);
         chk("R2 activate row", rr[br], 10 + b);
         chk("R2 act to col", cc[bc] - rc[br], T_RCD);
         chk("R3 hit is write", cw[bc + 1], 1);
         chk("R3 hit bank", cb[bc + 1], b);
         chk("R4 precharge", ra[br + 1], 0);
         chk("R4 pre to act", rc[br + 2] - rc[br + 1], T_RP);
         chk("R4 act to col", cc[bc + 2] - rc[br + 2], T_RCD);
         chk("R11 read count", nd - bd, 2);
         chk("R11 read latency", dc[bd] - cc[bc], RD_LAT);
         chk("R11 first tag", dt[bd], b);
         chk("R11 second tag", dt[bd + 1], (b + 3) % 16);
      end

      // R6 same bank spacing, R7 shared bus spacing, R9 wide column
      bc = nc;
      send(1'b0, 0, 40, 5, 1'b0, 1);
      send(1'b0, 0, 40, 6, 1'b0, 2);
      idle(10);
      chk("R6 same bank gap", cc[bc + 1] - cc[bc], T_CCD);
      bc = nc;
      send(1'b0, 1, 41, 63, 1'b0, 3);
      send(1'b0, 2, 42, 7, 1'b0, 4);
      idle(10);
      chk("R7 wide bus gap", cc[bc + 1] - cc[bc], BL_LEG);
      chk("R9 wide column kept", ccol[bc], 63);

      // R5 dual issue in one cycle
      br = nr; bc = nc;
      send(1'b0, 5, 99, 0, 1'b0, 5);
      idle(1);
      send(1'b0, 3, 43, 0, 1'b0, 6);
      idle(15);
      chk("R5 activate bank", rb[br + 1], 5);
      chk("R5 column bank", cb[bc], 3);
      chk("R5 same cycle", cc[bc] - rc[br + 1], 0);

      // R5 same-bank collision, column first
      br = nr; bc = nc;
      send(1'b0, 6, 70, 0, 1'b0, 7);
      send(1'b0, 6, 71, 0, 1'b0, 8);
      idle(30);
      chk("R5 row held after col", rc[br + 2] - cc[bc], T_CCD);
      chk("R5 second activate row", rr[br + 3], 71);
      chk("R4 second act to col", cc[bc + 1] - rc[br + 3], T_RCD);

      // split mode
      do_reset(1'b1);
      br = nr; bc = nc;
      send(1'b1, 2, 5, 63, 1'b0, 9);
      idle(12);
      chk("R8 split row bank", rb[br], 10);
      chk("R8 split col bank", cb[bc], 10);
      chk("R9 split column top bit", ccol[bc], 31);

      send(1'b0, 0, 1, 0, 1'b0, 0);
      send(1'b0, 1, 2, 0, 1'b0, 0);
      send(1'b1, 0, 3, 0, 1'b0, 0);
      send(1'b0, 2, 4, 0, 1'b0, 0);
      idle(30);

      bc = nc;
      send(1'b0, 0, 1, 0, 1'b0, 1);
      send(1'b0, 1, 2, 0, 1'b0, 2);
      idle(15);
      chk("R7 split same half gap", cc[bc + 1] - cc[bc], BL_PC);
      bc = nc;
      send(1'b0, 0, 1, 0, 1'b0, 1);
      send(1'b1, 0, 3, 0, 1'b0, 2);
      idle(15);
      chk("R7 split other half gap", cc[bc + 1] - cc[bc], 1);

      // R10 oldest ready first
      bc = nc;
      send(1'b0, 0, 1, 0, 1'b0, 1);
      send(1'b0, 1, 2, 0, 1'b0, 2);
      send(1'b0, 2, 4, 0, 1'b0, 3);
      idle(20);
      chk("R10 older first", cb[bc + 1], 1);
      chk("R10 younger second", cb[bc + 2], 2);
      chk("R7 queued gap", cc[bc + 2] - cc[bc + 1], BL_PC);
      bc = nc;
      send(1'b0, 3, 9, 0, 1'b0, 4);
      send(1'b0, 1, 2, 0, 1'b0, 5);
      idle(20);
      chk("R10 ready younger passes", cb[bc], 1);
      chk("R10 blocked older later", cb[bc + 1], 3);

      // R12 window full
      bd = nd;
      send(1'b1, 7, 1, 0, 1'b0, 10);
      send(1'b1, 7, 2, 0, 1'b0, 11);
      send(1'b1, 7, 3, 0, 1'b0, 12);
      send(1'b1, 7, 4, 0, 1'b0, 13);
      chk("R12 ready low when full", int'(req_ready), 0);
      idle(80);
      chk("R12 all returned", nd - bd, 4);
      for (int k = 0; k < 4; k++) chk("R11 return order", dt[bd + k], 10 + k);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule